// File: doc/BRIEF.md
# Gated Pulse-Count Sampler

This block turns a stream of single-cycle pulse events into digital samples. A front end of the voltage-to-frequency kind emits pulses at a rate that follows the input amplitude. The block lets these pulses through a gate for a programmable number of clock cycles and counts them. It then publishes the count as one sample and closes the gate for a short fixed interval. Quantization and sampling are therefore two separate steps. The quantizer only makes pulses, and the sample value is the number of pulses seen while the gate was open.

Two modes are provided. In rate mode, only the up line is counted and the sample is an unsigned pulse count. In incremental mode, crossings in the rising direction arrive on the up line and crossings in the falling direction arrive on the down line. Each line has its own counter. The sample is the signed difference of the two counts, which is the net change of the input over the window. Both counters stop at their largest value instead of wrapping around, and the sample then carries an overflow flag.

Top module: `pulse_gate_counter`

## Requirements
- R1: The open (pass) phase of the gate lasts `win_len` clock cycles. A `win_len` of 0 is treated as 1. `sample_valid` is high in the cycle right after the last pass cycle, and never earlier in that window.
- R2: Each strobe is followed by a closed (block) phase of exactly `BLOCK_CYCLES` cycles, counting the strobe cycle as the first. Pulses on either line during the block phase change no sample. The next pass phase starts in the cycle after the block phase ends.
- R3: When `mode_incr` is 0 (rate mode), the sample is the number of pass cycles in which `pulse_up` was high. It is zero-extended into `sample_cnt`, so the top bit is 0. `pulse_dn` has no effect on the sample in this mode.
- R4: `sample_valid` is high for exactly one cycle per window. `sample_cnt` and `overflow` change only in a strobe cycle and hold their values until the next strobe.
- R5: When `mode_incr` is 1 (incremental mode), the sample is the up count minus the down count. It is written as a two's complement number of `CNT_W`+1 bits. A cycle with both lines high adds one to each count.
- R6: Each count stops at 2^`CNT_W`-1. `overflow` is 1 in a sample when a pulse arrived on a counted line while that line's count was already at this maximum. A count that reaches the maximum exactly does not raise `overflow`.
- R7: In rate mode, only the up line can raise `overflow`. `overflow` applies to one sample only and is recomputed for every window.
- R8: `win_len` and `mode_incr` are captured at the start of each pass phase. Changes made while a window is open take effect only from the next window.
- R9: While `rst_n` is low, `sample_valid`, `sample_cnt` and `overflow` are 0. After reset the gate starts in the block phase, so the first pass phase begins `BLOCK_CYCLES` cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_incr | input | 1 | 0: rate mode, 1: incremental mode (captured per window) |
| win_len | input | WIN_W | Pass-phase length in cycles (captured per window, 0 acts as 1) |
| pulse_up | input | 1 | Pulse line, rate input or rising-direction crossings |
| pulse_dn | input | 1 | Falling-direction crossing pulses |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| sample_cnt | output | CNT_W+1 | Sample value, unsigned (rate) or two's complement (incremental) |
| overflow | output | 1 | A counted line saturated during the window of this sample |

## Verification
The bench builds the block with `CNT_W` = 4, `WIN_W` = 8 and `BLOCK_CYCLES` = 2. With only 4-bit counters, windows of 15 to 20 cycles can reach saturation. This lets the bench test both sides of the saturation limit: a count that lands exactly on 15, and counts that are pushed past 15 on either line. Window lengths of 0, 1 and 18 to 20 can all be set through the 8-bit length input. The short block phase is long enough to inject pulses that must be ignored, and short enough for every strobe cycle to fall inside the block phase.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    typedef enum logic {
        PH_BLOCK = 1'b0,
        PH_PASS  = 1'b1
    } gate_ph_e;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_UP  = 0;
    localparam int unsigned CH_DN  = 1;

endpackage

// File: rtl/gpc_gate.sv
module gpc_gate
    import gpc_pkg::*;
#(
    parameter int unsigned WIN_W        = 8,
    parameter int unsigned BLOCK_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len,
    input  logic             mode_in,
    output logic             pass_en,
    output logic             win_last,
    output logic             mode_win
);

    localparam logic [WIN_W-1:0] BLK_LAST = WIN_W'(BLOCK_CYCLES - 1);
    localparam logic [WIN_W-1:0] ONE      = WIN_W'(1);

    typedef struct packed {
        gate_ph_e         ph;
        logic [WIN_W-1:0] tmr;
        logic [WIN_W-1:0] lim;
        logic             mode;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     last_pass;

    always_comb begin
        st_d      = st_q;
        last_pass = (st_q.ph == PH_PASS) && (st_q.tmr == (st_q.lim - ONE));
        case (st_q.ph)
            PH_BLOCK: begin
                if (st_q.tmr == BLK_LAST) begin
                    st_d.ph   = PH_PASS;
                    st_d.tmr  = '0;
                    st_d.lim  = (win_len == '0) ? ONE : win_len;
                    st_d.mode = mode_in;
                end else begin
                    st_d.tmr = st_q.tmr + ONE;
                end
            end
            default: begin
                if (last_pass) begin
                    st_d.ph  = PH_BLOCK;
                    st_d.tmr = '0;
                end else begin
                    st_d.tmr = st_q.tmr + ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_BLOCK;
            st_q.tmr  <= '0;
            st_q.lim  <= ONE;
            st_q.mode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pass_en  = (st_q.ph == PH_PASS);
    assign win_last = last_pass;
    assign mode_win = st_q.mode;

endmodule

// File: rtl/gpc_sat_counter.sv
module gpc_sat_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_tot,
    output logic             sat_tot
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sat;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic    at_max;

    always_comb begin
        at_max  = (st_q.cnt == CNT_MAX);
        cnt_tot = st_q.cnt;
        sat_tot = st_q.sat;
        if (inc) begin
            if (at_max) begin
                sat_tot = 1'b1;
            end else begin
                cnt_tot = st_q.cnt + CNT_W'(1);
            end
        end
        if (clr) begin
            st_d.cnt = '0;
            st_d.sat = 1'b0;
        end else begin
            st_d.cnt = cnt_tot;
            st_d.sat = sat_tot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.sat <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;

endmodule

// File: rtl/gpc_result.sv
module gpc_result #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             mode,
    input  logic [CNT_W-1:0] up_cnt,
    input  logic [CNT_W-1:0] dn_cnt,
    input  logic             up_sat,
    input  logic             dn_sat,
    output logic             valid,
    output logic [CNT_W:0]   value,
    output logic             ovf
);

    typedef struct packed {
        logic           valid;
        logic [CNT_W:0] value;
        logic           ovf;
    } res_st_t;

    res_st_t st_d, st_q;
    logic [CNT_W:0] up_ext, dn_ext;

    always_comb begin
        st_d       = st_q;
        up_ext     = {1'b0, up_cnt};
        dn_ext     = {1'b0, dn_cnt};
        st_d.valid = load;
        if (load) begin
            if (mode) begin
                st_d.value = up_ext - dn_ext;
                st_d.ovf   = up_sat | dn_sat;
            end else begin
                st_d.value = up_ext;
                st_d.ovf   = up_sat;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.value <= '0;
            st_q.ovf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign value = st_q.value;
    assign ovf   = st_q.ovf;

endmodule

// File: rtl/pulse_gate_counter.sv
module pulse_gate_counter
    import gpc_pkg::*;
#(
    parameter int unsigned WIN_W        = 8,
    parameter int unsigned CNT_W        = 12,
    parameter int unsigned BLOCK_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_incr,
    input  logic [WIN_W-1:0] win_len,
    input  logic             pulse_up,
    input  logic             pulse_dn,
    output logic             sample_valid,
    output logic [CNT_W:0]   sample_cnt,
    output logic             overflow
);

    logic                pass_en;
    logic                win_last;
    logic                mode_win;
    logic [NUM_CH-1:0]   pulse_vec;
    logic [CNT_W-1:0]    ch_cnt_q [NUM_CH];
    logic [CNT_W-1:0]    ch_tot   [NUM_CH];
    logic [NUM_CH-1:0]   ch_sat;
    logic [CNT_W-1:0]    up_cnt_q;
    logic [CNT_W-1:0]    dn_cnt_q;

    assign pulse_vec[CH_UP] = pulse_up;
    assign pulse_vec[CH_DN] = pulse_dn;

    gpc_gate #(
        .WIN_W        (WIN_W),
        .BLOCK_CYCLES (BLOCK_CYCLES)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_len  (win_len),
        .mode_in  (mode_incr),
        .pass_en  (pass_en),
        .win_last (win_last),
        .mode_win (mode_win)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        gpc_sat_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (pass_en & pulse_vec[g]),
            .clr     (win_last),
            .cnt_q_o (ch_cnt_q[g]),
            .cnt_tot (ch_tot[g]),
            .sat_tot (ch_sat[g])
        );
    end

    assign up_cnt_q = ch_cnt_q[CH_UP];
    assign dn_cnt_q = ch_cnt_q[CH_DN];

    gpc_result #(
        .CNT_W (CNT_W)
    ) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (win_last),
        .mode   (mode_win),
        .up_cnt (ch_tot[CH_UP]),
        .dn_cnt (ch_tot[CH_DN]),
        .up_sat (ch_sat[CH_UP]),
        .dn_sat (ch_sat[CH_DN]),
        .valid  (sample_valid),
        .value  (sample_cnt),
        .ovf    (overflow)
    );

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic [CNT_W:0]   sample_cnt,
    input logic             mode_win,
    input logic             pass_en,
    input logic [CNT_W-1:0] up_cnt_q,
    input logic [CNT_W-1:0] dn_cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid); // R4

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_cnt) |-> sample_valid); // R4

    AST_BLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_en |-> (up_cnt_q == '0) && (dn_cnt_q == '0)); // R2

    AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt_q == CNT_MAX) |=> (up_cnt_q == CNT_MAX) || (up_cnt_q == '0)); // R6

    AST_DN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_cnt_q == CNT_MAX) |=> (dn_cnt_q == CNT_MAX) || (dn_cnt_q == '0)); // R6

    AST_RATE_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !mode_win) |-> !sample_cnt[CNT_W]); // R3

endmodule

bind pulse_gate_counter gpc_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_cnt   (sample_cnt),
    .mode_win     (mode_win),
    .pass_en      (pass_en),
    .up_cnt_q     (up_cnt_q),
    .dn_cnt_q     (dn_cnt_q)
);

// File: tb/pulse_gate_counter_tb.sv
module pulse_gate_counter_tb;

    localparam int unsigned WIN_W    = 8;
    localparam int unsigned CNT_W    = 4;
    localparam int unsigned BLK      = 2;
    localparam time         CLK_PER  = 10ns;
    localparam int          NVEC     = 13;

    typedef struct packed {
        logic         mode;
        logic [7:0]   win;
        logic [7:0]   nup;
        logic [7:0]   ndn;
        logic         flip;
        logic [4:0]   exp_cnt;
        logic         exp_ovf;
    } vec_t;

    // mode, win, n_up, n_dn, flip, expected count, expected overflow
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd6,  8'd4,  8'd0,  1'b0, 5'h04, 1'b0},  // R3 plain rate
        '{1'b0, 8'd10, 8'd5,  8'd9,  1'b0, 5'h05, 1'b0},  // R3 down ignored
        '{1'b1, 8'd8,  8'd3,  8'd7,  1'b0, 5'h1C, 1'b0},  // R5 negative net
        '{1'b1, 8'd5,  8'd4,  8'd4,  1'b0, 5'h00, 1'b0},  // R5 simultaneous
        '{1'b0, 8'd20, 8'd20, 8'd0,  1'b0, 5'h0F, 1'b1},  // R6 saturate up
        '{1'b0, 8'd15, 8'd15, 8'd0,  1'b0, 5'h0F, 1'b0},  // R6 exact max
        '{1'b1, 8'd20, 8'd20, 8'd2,  1'b0, 5'h0D, 1'b1},  // R6 incr up sat
        '{1'b1, 8'd18, 8'd1,  8'd18, 1'b0, 5'h12, 1'b1},  // R6 incr down sat
        '{1'b0, 8'd0,  8'd1,  8'd0,  1'b0, 5'h01, 1'b0},  // R1 zero length
        '{1'b1, 8'd1,  8'd0,  8'd1,  1'b0, 5'h1F, 1'b0},  // R1 single cycle
        '{1'b1, 8'd7,  8'd6,  8'd2,  1'b1, 5'h04, 1'b0},  // R8 mid-window change
        '{1'b0, 8'd3,  8'd3,  8'd3,  1'b0, 5'h03, 1'b0},  // R7 back to rate
        '{1'b0, 8'd18, 8'd2,  8'd18, 1'b0, 5'h02, 1'b0}   // R7 down sat ignored
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_incr = 1'b0;
    logic [WIN_W-1:0] win_len = 8'd4;
    logic             pulse_up = 1'b0;
    logic             pulse_dn = 1'b0;
    logic             sample_valid;
    logic [CNT_W:0]   sample_cnt;
    logic             overflow;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER / 2) clk = ~clk;

    pulse_gate_counter #(
        .WIN_W        (WIN_W),
        .CNT_W        (CNT_W),
        .BLOCK_CYCLES (BLK)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_incr    (mode_incr),
        .win_len      (win_len),
        .pulse_up     (pulse_up),
        .pulse_dn     (pulse_dn),
        .sample_valid (sample_valid),
        .sample_cnt   (sample_cnt),
        .overflow     (overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // returns number of negedges waited until sample_valid is seen
    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_valid && n < 200);
    endtask

    // entered at the negedge of a strobe cycle
    task automatic run_vec(input vec_t v, input int idx);
        logic [CNT_W:0] prev;
        int             weff;
        bit             early;
        prev      = sample_cnt;
        mode_incr = v.mode;
        win_len   = v.win;
        pulse_up  = 1'b1;            // block-phase noise
        pulse_dn  = 1'b1;
        @(negedge clk);
        chk($sformatf("R4 strobe single vec%0d", idx), {31'd0, sample_valid}, 32'd0);
        chk($sformatf("R4 hold vec%0d", idx), {27'd0, sample_cnt}, {27'd0, prev});
        @(negedge clk);
        weff  = (v.win == 8'd0) ? 1 : int'(v.win);
        early = 1'b0;
        for (int i = 0; i < weff; i++) begin
            if (sample_valid) early = 1'b1;
            pulse_up = (i < int'(v.nup));
            pulse_dn = (i < int'(v.ndn));
            if (v.flip && i == 1) begin
                mode_incr = ~v.mode;
                win_len   = 8'd2;
            end
            @(negedge clk);
        end
        pulse_up = 1'b1;
        pulse_dn = 1'b1;
        chk($sformatf("R1 no early strobe vec%0d", idx), {31'd0, early}, 32'd0);
        chk($sformatf("R1 strobe timing vec%0d", idx), {31'd0, sample_valid}, 32'd1);
        chk($sformatf("R2 R3 R5 R8 count vec%0d", idx), {27'd0, sample_cnt}, {27'd0, v.exp_cnt});
        chk($sformatf("R6 R7 overflow vec%0d", idx), {31'd0, overflow}, {31'd0, v.exp_ovf});
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", {31'd0, sample_valid}, 32'd0);
        chk("R9 reset count", {27'd0, sample_cnt}, 32'd0);
        chk("R9 reset overflow", {31'd0, overflow}, 32'd0);
        rst_n = 1'b1;
        wait_valid(n);
        chk("R9 first strobe delay", n, 32'd6);
        chk("R9 first sample empty", {27'd0, sample_cnt}, 32'd0);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k], k);
        end

        // mid-window reset
        mode_incr = 1'b0;
        win_len   = 8'd4;
        pulse_up  = 1'b0;
        pulse_dn  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset mid-window valid", {31'd0, sample_valid}, 32'd0);
        chk("R9 reset mid-window count", {27'd0, sample_cnt}, 32'd0);
        chk("R9 reset mid-window overflow", {31'd0, overflow}, 32'd0);
        pulse_up = 1'b1;
        rst_n    = 1'b1;
        wait_valid(n);
        chk("R9 strobe delay after reset", n, 32'd6);
        chk("R2 R3 count after reset", {27'd0, sample_cnt}, 32'd4);
        pulse_up = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule